// File: doc/BRIEF.md
# Next-PC Resolver with One-Instruction Delay Slot

This block decides where a 32-bit RISC core fetches next. Each cycle that an instruction issues, the core presents that instruction's PC, its decoded control-transfer kind, the two register operands, the 16-bit branch displacement and the 26-bit jump field. The block evaluates the condition, forms the target and reports the taken decision. For link kinds it also returns a write request to register 31 carrying the return address.

Control transfer is delayed by exactly one instruction. After a taken branch or jump the next fetch address is still the sequential one, so the following instruction (the delay slot) executes. The target is held in an internal register and becomes the fetch address after that slot instruction issues. Return addresses therefore point past the slot, at PC+8.

Top module: `nextpc_core`

## Requirements
- R1: After reset `npc_o` equals the parameter `RESET_PC` (default 32'hBFC0_0000), no redirect is pending, and with `issue_i` low both `taken_o` and `link_we_o` are 0.
- R2: Kind 1 (equal) is taken when `opa_i == opb_i`; kind 2 (not equal) is taken when they differ.
- R3: Kinds 3 (a <= 0), 4 (a > 0), 5 (a < 0), 6 (a >= 0), 7 (a < 0, linking) and 8 (a >= 0, linking) compare `opa_i` as a signed two's-complement value against zero.
- R4: A conditional branch target is `pc_i + 4 + (sign-extended off_i << 2)`, including negative displacements and wrap-around at 2^32.
- R5: Kinds 9 (jump) and 10 (jump with link) are always taken, with target `{pc_i[31:28], jtgt_i, 2'b00}`.
- R6: Kind 11 (register jump) is always taken and its target is `opa_i` unchanged.
- R7: When an issued instruction is taken, `npc_o` becomes `pc_i + 4` on the next edge; on the edge after the next issued instruction, `npc_o` becomes the saved target.
- R8: When an issued instruction is not taken or is kind 0 (no transfer) with nothing pending, `npc_o` becomes `pc_i + 4` on the next edge.
- R9: Kinds 7, 8 and 10 raise `link_we_o` during issue, whether or not taken, with `link_idx_o` = 31 and `link_val_o` = `pc_i + 8`; no other kind raises `link_we_o`.
- R10: While `issue_i` is low, `npc_o` and any pending target are held and `taken_o` is 0.
- R11: Kind 0 never reports taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction issues this cycle |
| pc_i | input | 32 | PC of the issuing instruction |
| kind_i | input | 4 | Control-transfer kind code (0..11) |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| off_i | input | 16 | Branch displacement in words |
| jtgt_i | input | 26 | Jump word-address field |
| npc_o | output | 32 | Address of the next instruction to fetch |
| taken_o | output | 1 | Issuing instruction transfers control |
| link_we_o | output | 1 | Return-address write request |
| link_idx_o | output | 5 | Destination register of the return address |
| link_val_o | output | 32 | Return address |

## Verification
The assertions assume that the instruction issuing while a redirect is pending is never itself a taken transfer, since a transfer inside the delay slot has no defined result. The stimulus follows every branch or jump with a kind-0 slot instruction at the sequential address. Stalls only lower `issue_i` and never change the pending state. The vectors mix taken and not-taken outcomes, positive, zero and negative operands, and backward and wrapping displacements. Directed cases cover stalling inside a pending redirect and a reset that discards one.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int XLEN     = 32;
  localparam int OFF_W    = 16;
  localparam int JT_W     = 26;
  localparam int RIDX_W   = 5;
  localparam int KIND_W   = 4;
  localparam int INSN_B   = 4;
  localparam int HI_W     = XLEN - JT_W - 2;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(31);

  typedef enum logic [KIND_W-1:0] {
    XK_NONE   = 4'd0,
    XK_EQ     = 4'd1,
    XK_NE     = 4'd2,
    XK_LEZ    = 4'd3,
    XK_GTZ    = 4'd4,
    XK_LTZ    = 4'd5,
    XK_GEZ    = 4'd6,
    XK_LTZ_LK = 4'd7,
    XK_GEZ_LK = 4'd8,
    XK_JMP    = 4'd9,
    XK_JMP_LK = 4'd10,
    XK_JREG   = 4'd11
  } xfer_kind_e;

  typedef logic [XLEN-1:0] addr_t;

  // sequential successor
  function automatic addr_t f_seq(input addr_t pc);
    return pc + addr_t'(INSN_B);
  endfunction

  // return address that steps over the delay slot
  function automatic addr_t f_ret(input addr_t pc);
    return pc + addr_t'(2 * INSN_B);
  endfunction

  // displacement in words, widened with sign and scaled to bytes
  function automatic addr_t f_brtgt(input addr_t pc, input logic [OFF_W-1:0] off);
    addr_t disp;
    disp = {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return f_seq(pc) + disp;
  endfunction

  // region bits of the PC, word field, byte alignment
  function automatic addr_t f_jtgt(input addr_t pc, input logic [JT_W-1:0] jt);
    return {pc[XLEN-1 -: HI_W], jt, 2'b00};
  endfunction
endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic              take_o,
  output logic              link_o,
  output logic              uncond_o
);
  logic a_neg, a_zero, ab_eq;

  assign a_neg  = opa_i[XLEN-1];
  assign a_zero = (opa_i == '0);
  assign ab_eq  = (opa_i == opb_i);

  always_comb begin
    take_o   = 1'b0;
    link_o   = 1'b0;
    uncond_o = 1'b0;
    case (xfer_kind_e'(kind_i))
      XK_EQ:     take_o = ab_eq;
      XK_NE:     take_o = !ab_eq;
      XK_LEZ:    take_o = a_neg || a_zero;
      XK_GTZ:    take_o = !a_neg && !a_zero;
      XK_LTZ:    take_o = a_neg;
      XK_GEZ:    take_o = !a_neg;
      XK_LTZ_LK: begin take_o = a_neg;  link_o = 1'b1; end
      XK_GEZ_LK: begin take_o = !a_neg; link_o = 1'b1; end
      XK_JMP:    begin take_o = 1'b1; uncond_o = 1'b1; end
      XK_JMP_LK: begin take_o = 1'b1; uncond_o = 1'b1; link_o = 1'b1; end
      XK_JREG:   begin take_o = 1'b1; uncond_o = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JT_W-1:0]   jtgt_i,
  output logic [XLEN-1:0]   tgt_o
);
  always_comb begin
    case (xfer_kind_e'(kind_i))
      XK_JMP, XK_JMP_LK: tgt_o = f_jtgt(pc_i, jtgt_i);
      XK_JREG:           tgt_o = opa_i;
      default:           tgt_o = f_brtgt(pc_i, off_i);
    endcase
  end
endmodule

// File: rtl/nextpc_core.sv
module nextpc_core
  import nextpc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_i,
  input  logic [31:0] pc_i,
  input  logic [3:0]  kind_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic [15:0] off_i,
  input  logic [25:0] jtgt_i,
  output logic [31:0] npc_o,
  output logic        taken_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_val_o
);
  logic cond_take, cond_link, cond_uncond;
  addr_t tgt_w;

  nextpc_cond u_cond (
    .kind_i  (kind_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .take_o  (cond_take),
    .link_o  (cond_link),
    .uncond_o(cond_uncond)
  );

  nextpc_target u_tgt (
    .kind_i (kind_i),
    .pc_i   (pc_i),
    .opa_i  (opa_i),
    .off_i  (off_i),
    .jtgt_i (jtgt_i),
    .tgt_o  (tgt_w)
  );

  // named events for the checks below
  logic  ev_take, ev_slot, ev_seq;
  logic  pend_q;
  addr_t pend_tgt_q, npc_q;

  assign ev_take = issue_i && cond_take && !pend_q;
  assign ev_slot = issue_i && pend_q;
  assign ev_seq  = issue_i && !pend_q;

  assign taken_o    = issue_i && cond_take;
  assign link_we_o  = issue_i && cond_link;
  assign link_idx_o = LINK_REG;
  assign link_val_o = f_ret(pc_i);
  assign npc_o      = npc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_q      <= RESET_PC;
      pend_q     <= 1'b0;
      pend_tgt_q <= '0;
    end else if (ev_slot) begin
      npc_q  <= pend_tgt_q;
      pend_q <= 1'b0;
    end else if (ev_seq) begin
      npc_q <= f_seq(pc_i);
      if (ev_take) begin
        pend_q     <= 1'b1;
        pend_tgt_q <= tgt_w;
      end
    end
  end

  // R7: a taken transfer still fetches its delay slot first
  p_slot_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> (npc_o == $past(pc_i) + 32'd4 && pend_q));
  // R7: the slot instruction consumes the pending redirect
  p_redirect_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slot |=> !pend_q);
  // R8: nothing pending after a non-taken issue
  p_fallthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_seq && !cond_take) |=> (!pend_q && npc_o == $past(pc_i) + 32'd4));
  // R10: stall holds state
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(npc_o) && $stable(pend_q)));
  // R10: no decision reported without issue
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |-> (!taken_o && !link_we_o));
  // R5/R6: unconditional kinds always transfer
  p_uncond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && cond_uncond) |-> taken_o);
  // R11: no-transfer kind never taken
  p_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i == 4'd0) |-> !taken_o);
  // R9: link write only for linking kinds
  p_link_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (kind_i == 4'd7 || kind_i == 4'd8 || kind_i == 4'd10));
  // input rule: no taken transfer in a delay slot
  p_no_nested_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slot |-> !cond_take);
endmodule

// File: tb/nextpc_core_tb.sv
module nextpc_core_tb_top;
  localparam logic [31:0] RST_PC = 32'hBFC0_0000;

  typedef struct packed {
    logic [3:0]  kind;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] off;
    logic [25:0] jt;
    logic        tk;
    logic [31:0] dst;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd1,  32'h0000_1000, 32'd5,          32'd5, 16'h0004, 26'h0, 1'b1, 32'h0000_1014}, // R2 R4
    '{4'd1,  32'h0000_1000, 32'd5,          32'd6, 16'h0004, 26'h0, 1'b0, 32'h0000_1008}, // R2 R8
    '{4'd2,  32'h0000_2000, 32'd1,          32'd2, 16'hFFFF, 26'h0, 1'b1, 32'h0000_2000}, // R2 R4
    '{4'd3,  32'h0000_3000, 32'd0,          32'd9, 16'h0010, 26'h0, 1'b1, 32'h0000_3044}, // R3
    '{4'd4,  32'h0000_3000, 32'd0,          32'd9, 16'h0010, 26'h0, 1'b0, 32'h0000_3008}, // R3
    '{4'd5,  32'h0000_4000, 32'hFFFF_FFFF,  32'd0, 16'h8000, 26'h0, 1'b1, 32'hFFFE_4004}, // R3 R4
    '{4'd6,  32'h0000_4000, 32'h8000_0000,  32'd0, 16'h8000, 26'h0, 1'b0, 32'h0000_4008}, // R3
    '{4'd4,  32'h0000_5000, 32'h7FFF_FFFF,  32'd0, 16'h0002, 26'h0, 1'b1, 32'h0000_500C}, // R3
    '{4'd7,  32'h0000_6000, 32'd1,          32'd0, 16'h0003, 26'h0, 1'b0, 32'h0000_6008}, // R9
    '{4'd8,  32'h0000_6000, 32'd0,          32'd0, 16'h0003, 26'h0, 1'b1, 32'h0000_6010}, // R9
    '{4'd9,  32'hA000_1000, 32'd0,          32'd0, 16'h0000, 26'h3FF_FFFF, 1'b1, 32'hAFFF_FFFC}, // R5
    '{4'd10, 32'h1234_5678, 32'd0,          32'd0, 16'h0000, 26'h000_0010, 1'b1, 32'h1000_0040}, // R5 R9
    '{4'd11, 32'h0000_8000, 32'h0040_0000,  32'd0, 16'h0000, 26'h0, 1'b1, 32'h0040_0000}, // R6
    '{4'd3,  32'h0000_7000, 32'h8000_0000,  32'd0, 16'h0100, 26'h0, 1'b1, 32'h0000_7404}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0;
  logic [3:0]  kind_i = '0;
  logic [15:0] off_i = '0;
  logic [25:0] jtgt_i = '0;
  logic [31:0] npc_o, link_val_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_idx_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nextpc_core #(.RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .pc_i(pc_i), .kind_i(kind_i),
    .opa_i(opa_i), .opb_i(opb_i), .off_i(off_i), .jtgt_i(jtgt_i),
    .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_val_o(link_val_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic drive(input logic iss, input logic [3:0] k, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] o, input logic [25:0] j);
    issue_i = iss; kind_i = k; pc_i = pc; opa_i = a; opb_i = b; off_i = o; jtgt_i = j;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 npc", npc_o, RST_PC);
    chk("R1 taken", {31'd0, taken_o}, 32'd0);
    chk("R1 link_we", {31'd0, link_we_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 R11: kind 0 at reset PC steps sequentially, never taken
    drive(1'b1, 4'd0, RST_PC, 32'd0, 32'd0, 16'h0001, 26'h1);
    #1 chk("R11 none taken", {31'd0, taken_o}, 32'd0);
    @(negedge clk);
    chk("R8 seq from reset", npc_o, RST_PC + 32'd4);

    foreach (VECS[i]) begin
      vec_t v;
      logic lk;
      v  = VECS[i];
      lk = (v.kind == 4'd7 || v.kind == 4'd8 || v.kind == 4'd10);
      drive(1'b1, v.kind, v.pc, v.a, v.b, v.off, v.jt);
      #1;
      chk($sformatf("R2/R3 taken v%0d", i), {31'd0, taken_o}, {31'd0, v.tk});
      chk($sformatf("R9 link_we v%0d", i), {31'd0, link_we_o}, {31'd0, lk});
      if (lk) begin
        chk("R9 link_val", link_val_o, v.pc + 32'd8);
        chk("R9 link_idx", {27'd0, link_idx_o}, 32'd31);
      end
      @(negedge clk);
      chk($sformatf("R7 slot fetch v%0d", i), npc_o, v.pc + 32'd4);
      drive(1'b1, 4'd0, v.pc + 32'd4, 32'd0, 32'd0, 16'h0, 26'h0);
      @(negedge clk);
      chk($sformatf("R4/R5/R6/R7 dest v%0d", i), npc_o, v.dst);
      drive(1'b0, 4'd0, 32'd0, 32'd0, 32'd0, 16'h0, 26'h0);
    end

    // R10: stall during a pending redirect
    @(negedge clk);
    drive(1'b1, 4'd1, 32'h0000_9000, 32'd7, 32'd7, 16'h0020, 26'h0);
    @(negedge clk);
    drive(1'b0, 4'd9, 32'h0000_9004, 32'd0, 32'd0, 16'h0, 26'h3);
    #1 chk("R10 no taken while stalled", {31'd0, taken_o}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 npc held", npc_o, 32'h0000_9004);
    drive(1'b1, 4'd0, 32'h0000_9004, 32'd0, 32'd0, 16'h0, 26'h0);
    @(negedge clk);
    chk("R10 R7 redirect after stall", npc_o, 32'h0000_9084);

    // R1: reset drops a pending redirect
    drive(1'b1, 4'd9, 32'h0000_9084, 32'd0, 32'd0, 16'h0, 26'h55);
    @(negedge clk);
    drive(1'b0, 4'd0, 32'd0, 32'd0, 32'd0, 16'h0, 26'h0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 npc after re-reset", npc_o, RST_PC);
    rst_n = 1'b1;
    drive(1'b1, 4'd0, RST_PC, 32'd0, 32'd0, 16'h0, 26'h0);
    @(negedge clk);
    chk("R1 pending cleared", npc_o, RST_PC + 32'd4);
    drive(1'b0, 4'd0, 32'd0, 32'd0, 32'd0, 16'h0, 26'h0);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule